// File: doc/BRIEF.md
# Interrupt Source Gate and Router

This block holds the per-source configuration for a bank of interrupt inputs and decides, cycle by cycle, which source is handed to which processor. Each source has a vector/priority word (mask, read-only activity flag, delivery mode, polarity, sense, priority, vector) and a destination word (processor-select bits and a critical-output selector). Raw inputs become pending state, either by following a level or by catching a rising edge. A pending source is forwarded only when it is unmasked, has a nonzero priority, is not already active and has at least one processor selected.

One eligible source, the lowest-numbered, is routed per cycle. It goes either to every selected processor (directed mode) or to a single processor picked round-robin (distributed mode). The result is a one-cycle request on per-processor normal or critical request lines, carrying the source index, priority and vector. The forwarded source becomes active, and stays so until the acknowledge side returns a clear for it. Software reaches both words per source through a 32-bit register port with a combinational read.

Top module: `irq_src_router`

## Requirements
- R1: After reset every vector/priority word reads 0x80000000, every destination word reads 0x00000001, and no request line is high.
- R2: A write to a vector/priority word (address bit 0 = 0, source index in the upper address bits) updates only bits 31 (mask), 29 (mode), 23 (polarity), 22 (sense), 20:16 (priority) and 7:0 (vector). Bit 30 (activity) keeps its value and the other bits read 0. A write to a destination word (address bit 0 = 1) keeps bits 31:30 and the low NUM_CPU bits and drops the rest.
- R3: With sense = 1, pending equals the effective level (input XOR polarity) sampled each clock, and an effective low also clears activity.
- R4: With sense = 0, a rising edge of the effective level sets pending. Pending stays set until a clear, and a held input does not re-deliver.
- R5: A source is not delivered while it is not pending, masked, at priority 0, active, or has no processor selected. Removing the blocker by a register write delivers it on the next cycle.
- R6: A source that is eligible after clock edge t appears on the request lines, with its index, priority and vector, for exactly the cycle after edge t+1, and its activity bit reads 1 from then on.
- R7: When several sources are eligible, the lowest index goes first, one source per cycle.
- R8: If the processor-select bits name exactly the last-served processor, only that processor receives the source, in either mode.
- R9: In directed mode (bit 29 = 0) every selected processor receives the source.
- R10: In distributed mode (bit 29 = 1) the search starts at the processor after the last-served one and wraps around. The first selected processor found receives the source and is recorded as last served. The last-served value is 0 after reset.
- R11: With CRIT_EN set, destination bit (30 - i) sends processor i's request to its critical line instead of the normal one. Because writes keep only bits 31:30, this takes effect for processor 0 only.
- R12: A clear (ack_clr with ack_src) drops activity. For an edge source it also drops pending. A level source whose input is still asserted is delivered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Raw interrupt inputs, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | SRC_W+1 | Bit 0 selects destination word; upper bits select source |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| ack_clr | input | 1 | Activity clear from an acknowledge unit |
| ack_src | input | SRC_W | Source index for ack_clr |
| dlv_irq | output | NUM_CPU | Per-processor normal request pulse |
| dlv_crit | output | NUM_CPU | Per-processor critical request pulse |
| dlv_src | output | SRC_W | Index of the source being delivered |
| dlv_prio | output | 5 | Priority of the source being delivered |
| dlv_vec | output | 8 | Vector of the source being delivered |

## Verification
The bench sweeps every source's two words with distinct patterns through an empty processor set, so that a wrong write mask or a writable activity bit shows up as a readback mismatch. It walks each gating condition in turn and then lifts it with a register write. A design that ignored priority 0 or an empty set would deliver early, and one that latched eligibility late would miss the expected cycle. Distributed delivery runs long enough to wrap and then narrows the set, and an off-by-one in the search start or a failure to record the winner gives the wrong processor. Simultaneous edges on three sources check the lowest-first order. A level source cleared while still asserted has to come back, which a design that also cleared pending on level sources would fail.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int VP_MSK   = 31;
    localparam int VP_ACT   = 30;
    localparam int VP_MODE  = 29;
    localparam int VP_POL   = 23;
    localparam int VP_SENSE = 22;
    localparam int PRIO_LSB = 16;
    localparam int PRIO_W   = 5;
    localparam int VEC_W    = 8;
    localparam int CRIT_TOP = 30;

    localparam logic [31:0] VP_WMASK   = 32'hA0DF_00FF;
    localparam logic [31:0] VP_RST     = 32'h8000_0000;
    localparam logic [31:0] DST_RST    = 32'h0000_0001;
    localparam logic [31:0] DST_HIMASK = 32'hC000_0000;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2,
    parameter bit CRIT_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_in,
    input  logic               wr_vp,
    input  logic               wr_dst,
    input  logic [31:0]        wdata,
    input  logic               clr,
    input  logic               take,
    input  logic [CPU_W-1:0]   new_last,
    input  logic               upd_last,
    output logic [31:0]        vp_q,
    output logic [31:0]        dst_q,
    output logic [CPU_W-1:0]   last_q,
    output logic [NUM_CPU-1:0] dsel,
    output logic [NUM_CPU-1:0] crit_sel,
    output logic               elig
);
    localparam logic [31:0] DST_WMASK = DST_HIMASK | 32'((64'd1 << NUM_CPU) - 64'd1);

    typedef struct packed {
        logic [31:0]      vp;
        logic [31:0]      dst;
        logic             pend;
        logic             lvl;
        logic [CPU_W-1:0] last;
    } cell_t;

    cell_t s_d, s_q;
    logic  eff;
    logic  lvl_drop;

    always_comb begin
        s_d      = s_q;
        eff      = irq_in ^ s_q.vp[VP_POL];
        lvl_drop = s_q.vp[VP_SENSE] && !eff;
        s_d.lvl  = eff;
        if (s_q.vp[VP_SENSE]) begin
            s_d.pend = eff;
            if (!eff) s_d.vp[VP_ACT] = 1'b0;
        end else if (eff && !s_q.lvl) begin
            s_d.pend = 1'b1;
        end
        if (clr) begin
            s_d.vp[VP_ACT] = 1'b0;
            if (!s_q.vp[VP_SENSE]) s_d.pend = 1'b0;
        end
        if (take) begin
            s_d.vp[VP_ACT] = 1'b1;
            if (upd_last) s_d.last = new_last;
        end
        if (wr_vp)  s_d.vp  = (s_d.vp & (32'h1 << VP_ACT)) | (wdata & VP_WMASK);
        if (wr_dst) s_d.dst = wdata & DST_WMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.vp   <= VP_RST;
            s_q.dst  <= DST_RST;
            s_q.pend <= 1'b0;
            s_q.lvl  <= 1'b0;
            s_q.last <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign vp_q   = s_q.vp;
    assign dst_q  = s_q.dst;
    assign last_q = s_q.last;
    assign dsel   = s_q.dst[NUM_CPU-1:0];
    assign elig   = s_q.pend && !s_q.vp[VP_MSK] && !s_q.vp[VP_ACT]
                 && (s_q.vp[PRIO_LSB +: PRIO_W] != '0)
                 && (s_q.dst[NUM_CPU-1:0] != '0);

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_crit
        if (CRIT_EN) begin : g_on
            assign crit_sel[i] = s_q.dst[CRIT_TOP-i];
        end else begin : g_off
            assign crit_sel[i] = 1'b0;
        end
    end

    AST_TAKE_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> elig); // R5
    AST_ACT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vp && !take && !clr && !lvl_drop) |=> (s_q.vp[VP_ACT] == $past(s_q.vp[VP_ACT]))); // R2
    AST_TAKE_SETS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> s_q.vp[VP_ACT]); // R6
    AST_EDGE_HOLDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.vp[VP_SENSE] && s_q.pend && !clr && !wr_vp) |=> s_q.pend); // R4
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] elig,
    output logic         any,
    output logic [W-1:0] sel
);
    always_comb begin
        any = |elig;
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) sel = W'(i);
        end
    end

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (elig[sel] && ((elig & ((N'(1) << sel) - N'(1))) == '0))); // R7
endmodule

// File: rtl/irq_dest_route.sv
module irq_dest_route #(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CPU-1:0] dsel,
    input  logic [NUM_CPU-1:0] crit_sel,
    input  logic               mode,
    input  logic [CPU_W-1:0]   last,
    output logic [NUM_CPU-1:0] int_vec,
    output logic [NUM_CPU-1:0] crit_vec,
    output logic [CPU_W-1:0]   new_last,
    output logic               upd_last
);
    logic [NUM_CPU-1:0] tgt;
    logic [NUM_CPU-1:0] last_oh;
    logic [CPU_W-1:0]   cand;
    logic               found;

    always_comb begin
        last_oh  = NUM_CPU'(1) << last;
        tgt      = '0;
        new_last = last;
        upd_last = 1'b0;
        found    = 1'b0;
        cand     = '0;
        if (dsel == last_oh) begin
            tgt = dsel;
        end else if (!mode) begin
            tgt = dsel;
        end else begin
            for (int k = 1; k < NUM_CPU; k++) begin
                cand = CPU_W'((int'(last) + k) % NUM_CPU);
                if (!found && dsel[cand]) begin
                    found     = 1'b1;
                    tgt[cand] = 1'b1;
                    new_last  = cand;
                    upd_last  = 1'b1;
                end
            end
        end
        crit_vec = tgt & crit_sel;
        int_vec  = tgt & ~crit_sel;
    end

    AST_DIST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && dsel != '0) |-> $onehot(int_vec | crit_vec)); // R10
    AST_DIST_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && ((dsel & ~last_oh) != '0)) |-> (upd_last && new_last != last)); // R10
    AST_DIRECTED_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> ((int_vec | crit_vec) == dsel)); // R9
endmodule

// File: rtl/irq_src_router.sv
module irq_src_router
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_CPU = 4,
    parameter bit CRIT_EN = 1'b1,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               reg_wr,
    input  logic [SRC_W:0]     reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               ack_clr,
    input  logic [SRC_W-1:0]   ack_src,
    output logic [NUM_CPU-1:0] dlv_irq,
    output logic [NUM_CPU-1:0] dlv_crit,
    output logic [SRC_W-1:0]   dlv_src,
    output logic [PRIO_W-1:0]  dlv_prio,
    output logic [VEC_W-1:0]   dlv_vec
);
    typedef struct packed {
        logic [NUM_CPU-1:0] irq;
        logic [NUM_CPU-1:0] crit;
        logic [SRC_W-1:0]   src;
        logic [PRIO_W-1:0]  prio;
        logic [VEC_W-1:0]   vec;
    } out_t;

    logic [NUM_SRC-1:0][31:0]        vp_all;
    logic [NUM_SRC-1:0][31:0]        dst_all;
    logic [NUM_SRC-1:0][CPU_W-1:0]   last_all;
    logic [NUM_SRC-1:0][NUM_CPU-1:0] dsel_all;
    logic [NUM_SRC-1:0][NUM_CPU-1:0] crit_all;
    logic [NUM_SRC-1:0]              elig;
    logic [NUM_SRC-1:0]              take;
    logic                            any;
    logic [SRC_W-1:0]                sel;
    logic [NUM_CPU-1:0]              int_vec;
    logic [NUM_CPU-1:0]              crit_vec;
    logic [CPU_W-1:0]                new_last;
    logic                            upd_last;
    logic [SRC_W-1:0]                ridx;
    out_t                            out_d, out_q;

    assign ridx = reg_addr[SRC_W:1];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign take[i] = any && (sel == SRC_W'(i));
        irq_src_cell #(
            .NUM_CPU (NUM_CPU),
            .CPU_W   (CPU_W),
            .CRIT_EN (CRIT_EN)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_in   (irq_in[i]),
            .wr_vp    (reg_wr && !reg_addr[0] && ridx == SRC_W'(i)),
            .wr_dst   (reg_wr &&  reg_addr[0] && ridx == SRC_W'(i)),
            .wdata    (reg_wdata),
            .clr      (ack_clr && ack_src == SRC_W'(i)),
            .take     (take[i]),
            .new_last (new_last),
            .upd_last (upd_last),
            .vp_q     (vp_all[i]),
            .dst_q    (dst_all[i]),
            .last_q   (last_all[i]),
            .dsel     (dsel_all[i]),
            .crit_sel (crit_all[i]),
            .elig     (elig[i])
        );
    end

    irq_lowest_pick #(.N(NUM_SRC), .W(SRC_W)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .any   (any),
        .sel   (sel)
    );

    irq_dest_route #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .dsel     (dsel_all[sel]),
        .crit_sel (crit_all[sel]),
        .mode     (vp_all[sel][VP_MODE]),
        .last     (last_all[sel]),
        .int_vec  (int_vec),
        .crit_vec (crit_vec),
        .new_last (new_last),
        .upd_last (upd_last)
    );

    always_comb begin
        reg_rdata = reg_addr[0] ? dst_all[ridx] : vp_all[ridx];
    end

    always_comb begin
        out_d = '0;
        if (any) begin
            out_d.irq  = int_vec;
            out_d.crit = crit_vec;
            out_d.src  = sel;
            out_d.prio = vp_all[sel][PRIO_LSB +: PRIO_W];
            out_d.vec  = vp_all[sel][VEC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dlv_irq  = out_q.irq;
    assign dlv_crit = out_q.crit;
    assign dlv_src  = out_q.src;
    assign dlv_prio = out_q.prio;
    assign dlv_vec  = out_q.vec;

    AST_IRQ_CRIT_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.irq & out_q.crit) == '0); // R11
    AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (|(out_q.irq | out_q.crit)) |=> (!(|(out_q.irq | out_q.crit)) || out_q.src != $past(out_q.src))); // R6
endmodule

// File: tb/tb_irq_src_router.sv
module tb_irq_src_router;
    localparam int NS = 16;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ack_clr = 1'b0;
    logic [3:0]  ack_src = '0;
    logic [3:0]  dlv_irq, dlv_crit, dlv_src;
    logic [4:0]  dlv_prio;
    logic [7:0]  dlv_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_src_router #(.NUM_SRC(NS), .NUM_CPU(NC), .CRIT_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ack_clr(ack_clr), .ack_src(ack_src), .dlv_irq(dlv_irq),
        .dlv_crit(dlv_crit), .dlv_src(dlv_src), .dlv_prio(dlv_prio), .dlv_vec(dlv_vec)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wreg(int s, bit dsel, logic [31:0] d);
        reg_addr  = 5'((s << 1) | int'(dsel));
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rreg(int s, bit dsel, output logic [31:0] d);
        reg_addr = 5'((s << 1) | int'(dsel));
        #1;
        d = reg_rdata;
    endtask

    task automatic clr(int s);
        ack_clr = 1'b1;
        ack_src = 4'(s);
        @(negedge clk);
        ack_clr = 1'b0;
    endtask

    task automatic chk_dlv(string tag, logic [3:0] ei, logic [3:0] ec, int es, logic [4:0] ep, logic [7:0] ev);
        chk({tag, " normal lines"}, 32'(dlv_irq), 32'(ei));
        chk({tag, " critical lines"}, 32'(dlv_crit), 32'(ec));
        chk({tag, " source/prio/vec"}, {15'd0, dlv_src, dlv_prio, dlv_vec}, {15'd0, 4'(es), ep, ev});
    endtask

    task automatic chk_quiet(string tag);
        chk({tag, " no request"}, 32'(dlv_irq | dlv_crit), 32'd0);
    endtask

    function automatic int nxt(int last, logic [3:0] d);
        if (d == 4'(1 << last)) return last;
        for (int k = 1; k < NC; k++) begin
            if (d[(last + k) % NC]) return (last + k) % NC;
        end
        return last;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] p;
        int last;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        for (int s = 0; s < NS; s++) begin
            rreg(s, 1'b0, rd); chk("R1 vp reset", rd, 32'h8000_0000);
            rreg(s, 1'b1, rd); chk("R1 dest reset", rd, 32'h0000_0001);
        end
        chk_quiet("R1 reset");

        // R2 write masks, swept over all sources behind an empty processor set
        for (int s = 0; s < NS; s++) begin
            p = (32'(s) * 32'h1357_9BDF) ^ 32'h5A5A_5A5A;
            wreg(s, 1'b1, 32'h3FFF_FFF0);
            rreg(s, 1'b1, rd); chk("R2 dest drop", rd, 32'h0);
            wreg(s, 1'b0, p | 32'h4000_0000);
            rreg(s, 1'b0, rd); chk("R2 vp mask", rd, p & 32'hA0DF_00FF);
            wreg(s, 1'b0, 32'h8040_0000);
            wreg(s, 1'b0, 32'h8000_0000);
            wreg(s, 1'b1, p);
            rreg(s, 1'b1, rd); chk("R2 dest mask", rd, p & 32'hC000_000F);
            wreg(s, 1'b1, 32'h1);
        end
        tick();
        chk_quiet("R2 sweep");

        // R9 R6 directed delivery, R4 edge behaviour, R12 clear
        wreg(2, 1'b1, 32'hB);
        wreg(2, 1'b0, 32'h0005_0042);
        tick();
        chk_quiet("R5 not pending");
        irq_in[2] = 1'b1;
        tick(); tick();
        chk_dlv("R9 R6 directed", 4'hB, 4'h0, 2, 5'd5, 8'h42);
        tick();
        chk_quiet("R6 one-cycle pulse");
        rreg(2, 1'b0, rd); chk("R6 activity set", rd, 32'h4005_0042);
        wreg(2, 1'b0, 32'h0005_0042);
        rreg(2, 1'b0, rd); chk("R2 activity read-only", rd, 32'h4005_0042);
        chk_quiet("R5 active blocks");
        clr(2);
        tick();
        chk_quiet("R4 held edge input");
        rreg(2, 1'b0, rd); chk("R12 clear activity", rd, 32'h0005_0042);
        irq_in[2] = 1'b0; tick();
        irq_in[2] = 1'b1; tick(); tick();
        chk_dlv("R4 new edge", 4'hB, 4'h0, 2, 5'd5, 8'h42);
        clr(2); irq_in[2] = 1'b0; tick();

        // R5 gating conditions, each lifted by a write
        wreg(4, 1'b1, 32'h4);
        wreg(4, 1'b0, 32'h8003_0044);
        irq_in[4] = 1'b1;
        for (int k = 0; k < 3; k++) begin tick(); chk_quiet("R5 masked"); end
        wreg(4, 1'b0, 32'h0003_0044); tick();
        chk_dlv("R5 unmask", 4'h4, 4'h0, 4, 5'd3, 8'h44);
        clr(4); irq_in[4] = 1'b0; tick();
        wreg(4, 1'b0, 32'h0000_0044);
        irq_in[4] = 1'b1;
        for (int k = 0; k < 3; k++) begin tick(); chk_quiet("R5 priority zero"); end
        wreg(4, 1'b0, 32'h0003_0044); tick();
        chk_dlv("R5 priority set", 4'h4, 4'h0, 4, 5'd3, 8'h44);
        clr(4); irq_in[4] = 1'b0; tick();
        wreg(4, 1'b1, 32'h0);
        irq_in[4] = 1'b1;
        for (int k = 0; k < 3; k++) begin tick(); chk_quiet("R5 empty set"); end
        wreg(4, 1'b1, 32'h2); tick();
        chk_dlv("R5 set filled", 4'h2, 4'h0, 4, 5'd3, 8'h44);
        clr(4); irq_in[4] = 1'b0; tick();

        // R3 level source, active low; R8 single last-served target; R12 level redelivery
        wreg(5, 1'b0, 32'h00C3_0055);
        tick(); tick();
        chk_dlv("R3 R8 level", 4'h1, 4'h0, 5, 5'd3, 8'h55);
        irq_in[5] = 1'b1; tick();
        rreg(5, 1'b0, rd); chk("R3 low clears activity", rd, 32'h00C3_0055);
        chk_quiet("R3 level low");
        irq_in[5] = 1'b0; tick(); tick();
        chk_dlv("R3 level again", 4'h1, 4'h0, 5, 5'd3, 8'h55);
        clr(5);
        chk_quiet("R12 gap");
        tick();
        chk_dlv("R12 level redelivery", 4'h1, 4'h0, 5, 5'd3, 8'h55);
        wreg(5, 1'b0, 32'h80C3_0055);
        irq_in[5] = 1'b1; tick();

        // R10 distributed round robin, then R8 with only the last-served processor
        wreg(6, 1'b1, 32'hF);
        wreg(6, 1'b0, 32'h2007_0066);
        last = 0;
        for (int k = 0; k < 10; k++) begin
            if (k == 6) wreg(6, 1'b1, 32'h5);
            if (k == 8) wreg(6, 1'b1, 32'(1 << last));
            irq_in[6] = 1'b1; tick(); tick();
            p = (k < 6) ? 32'hF : ((k < 8) ? 32'h5 : 32'(1 << last));
            last = nxt(last, p[3:0]);
            chk_dlv((k < 8) ? "R10 round robin" : "R8 last only", 4'(1 << last), 4'h0, 6, 5'd7, 8'h66);
            clr(6); irq_in[6] = 1'b0; tick();
        end

        // R7 lowest index first
        foreach (p[i]) begin end
        wreg(1, 1'b1, 32'h8); wreg(8, 1'b1, 32'h8); wreg(9, 1'b1, 32'h8);
        wreg(1, 1'b0, 32'h0002_0011); wreg(8, 1'b0, 32'h0002_0018); wreg(9, 1'b0, 32'h0002_0019);
        irq_in[1] = 1'b1; irq_in[8] = 1'b1; irq_in[9] = 1'b1;
        tick(); tick();
        chk_dlv("R7 first", 4'h8, 4'h0, 1, 5'd2, 8'h11);
        tick();
        chk_dlv("R7 second", 4'h8, 4'h0, 8, 5'd2, 8'h18);
        tick();
        chk_dlv("R7 third", 4'h8, 4'h0, 9, 5'd2, 8'h19);
        tick();
        chk_quiet("R7 drained");
        clr(1); clr(8); clr(9);
        irq_in[1] = 1'b0; irq_in[8] = 1'b0; irq_in[9] = 1'b0; tick();

        // R11 critical output selection
        wreg(7, 1'b1, 32'h4000_0003);
        rreg(7, 1'b1, rd); chk("R11 dest readback", rd, 32'h4000_0003);
        wreg(7, 1'b0, 32'h0004_0077);
        irq_in[7] = 1'b1; tick(); tick();
        chk_dlv("R11 crit cpu0", 4'h2, 4'h1, 7, 5'd4, 8'h77);
        clr(7); irq_in[7] = 1'b0; tick();
        wreg(7, 1'b1, 32'h2000_0003);
        rreg(7, 1'b1, rd); chk("R11 bit29 dropped", rd, 32'h0000_0003);
        irq_in[7] = 1'b1; tick(); tick();
        chk_dlv("R11 no crit", 4'h3, 4'h0, 7, 5'd4, 8'h77);
        clr(7); irq_in[7] = 1'b0; tick();
        wreg(7, 1'b1, 32'h4000_0001);
        irq_in[7] = 1'b1; tick(); tick();
        chk_dlv("R11 crit only", 4'h0, 4'h1, 7, 5'd4, 8'h77);
        clr(7); irq_in[7] = 1'b0; tick();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule